// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block generates the two digital control lines of a 132-slot linear photodiode array: a serial start pulse (`sens_si_o`) and a sensor clock (`sens_clk_o`), both derived from the system clock. A readout frame starts in one of three ways: a start pulse, a held request, or continuous mode. Each frame is one start pulse followed by 132 sensor clock periods. The slots come out in a fixed order: two dummy slots, then the 128 real pixels, then two more dummy slots.

In every slot the block emits a one-cycle strobe, a programmable delay after the sensor clock falls, so that an external converter samples the analog output after it has settled. Each strobe comes with the slot number and a flag that marks a real pixel. After the last slot, the block holds off the next start pulse for an integration gap. The gap is set by a register, and the block never lets it fall below 10 µs. The half-period register is raised to the smallest value that meets the sensor's 320 ns minimum pulse width and its 1 MHz maximum clock rate. Both the half-period and the gap are latched when a frame begins.

Top module: `lsa_sequencer`

## Requirements
- R1: While reset is low, and directly after it, `sens_si_o`, `sens_clk_o`, `pix_valid_o`, `frame_done_o` and `busy_o` are all low.
- R2: A frame begins with `sens_si_o` rising. `sens_clk_o` rises exactly H system clocks later. `sens_si_o` falls in the same cycle as the first `sens_clk_o` falling edge, so only one sensor clock rise ever captures it.
- R3: Each frame contains exactly 132 `sens_clk_o` pulses. Every high phase and every low phase lasts exactly H system clocks.
- R4: H = max(`div_i`, 50) at the default 100 MHz system clock. 50 is the smallest half-period that meets both the 320 ns width limit and the 1 MHz rate limit. `div_i` is sampled when the frame begins.
- R5: There is exactly one `pix_valid_o` pulse per slot, D+1 system clocks after `sens_clk_o` falls, where D = min(`dly_i`, H-2). No strobe occurs outside a frame.
- R6: `pix_idx_o` runs 0 to 131 in order. `pix_real_o` is high only for slots 2 to 129, which gives exactly 128 real slots per frame.
- R7: `frame_done_o` is a one-cycle pulse, exactly H system clocks after the last `sens_clk_o` falling edge. `busy_o` is high from the rise of `sens_si_o` to the end of the gap.
- R8: The next `sens_si_o` rise comes no sooner than G+1 system clocks after `frame_done_o`, where G = max(`int_i`, 1000), that is 10 µs at 100 MHz, sampled at frame start. It comes exactly then when a request is pending or continuous mode is on.
- R9: A `start_i` pulse while `busy_o` is high is held and runs exactly one more frame after the gap. It does not disturb the frame in progress, and register changes during a frame do not affect that frame.
- R10: With `cont_i` high, frames repeat back to back. Dropping `cont_i` during a gap ends the sequence after the current gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-frame request pulse |
| cont_i | input | 1 | Continuous readout enable |
| div_i | input | DIV_W | Requested sensor clock half-period in system clocks |
| int_i | input | INT_W | Requested integration gap in system clocks |
| dly_i | input | DLY_W | Strobe delay after sensor clock falling edge |
| sens_si_o | output | 1 | Serial start line to the array |
| sens_clk_o | output | 1 | Clock line to the array |
| pix_valid_o | output | 1 | Converter sample strobe, one per slot |
| pix_real_o | output | 1 | Current slot holds a real pixel |
| pix_idx_o | output | SLOT_W | Slot number 0..131 |
| frame_done_o | output | 1 | One-cycle pulse after the last slot |
| busy_o | output | 1 | Frame or integration gap in progress |

## Verification
The bench drives a half-period below the legal floor, a gap below 10 µs, and a strobe delay larger than the low phase. A design that skipped any of these clamps would produce pulses that are too short, a gap that is too brief, or a strobe that lands in the next high phase or never fires. A start request arrives in the middle of a frame, together with register changes. A design that dropped the request would run one frame too few, and a design that did not latch the registers would reshape the running frame. Continuous mode is checked for exact back-to-back gaps and for a clean stop, so a leftover frame or an off-by-one gap is reported. Slot counting is checked per frame against 132 pulses, 132 strobes and 128 real flags, which catches a dummy slot lost or misflagged at either end.

// File: rtl/lsa_pkg.sv
// Shared types and timing-limit helpers for the linear sensor sequencer.
// Assumes the system clock frequency is given in Hz.
package lsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;

    // Smallest half-period meeting both the 320 ns width and the 1 MHz rate limit.
    function automatic int unsigned min_half(input longint unsigned hz);
        longint unsigned by_width;
        longint unsigned by_rate;
        by_width = (hz * 64'd32 + 64'd99_999_999) / 64'd100_000_000;
        by_rate  = (hz + 64'd1_999_999) / 64'd2_000_000;
        return int'((by_width > by_rate) ? by_width : by_rate);
    endfunction

    // Ticks covering the 10 us minimum integration gap.
    function automatic int unsigned min_gap(input longint unsigned hz);
        return int'((hz + 64'd99_999) / 64'd100_000);
    endfunction

endpackage

// File: rtl/lsa_param_clamp.sv
// Raises the requested half-period and gap to their legal minima and limits
// the strobe delay so that it lands inside the low phase.
// Assumes DLY_W <= DIV_W and HALF_MIN >= 2.
module lsa_param_clamp #(
    parameter int DIV_W    = 16,
    parameter int INT_W    = 24,
    parameter int DLY_W    = 8,
    parameter int HALF_MIN = 50,
    parameter int GAP_MIN  = 1000
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic [DIV_W-1:0] half_o,
    output logic [INT_W-1:0] gap_o,
    output logic [DIV_W-1:0] dly_o
);
    logic [DIV_W-1:0] half_m2;
    logic [DIV_W-1:0] dly_ext;

    // Apply the floors and the in-phase delay limit.
    always_comb begin
        half_o  = (div_i < DIV_W'(HALF_MIN)) ? DIV_W'(HALF_MIN) : div_i;
        gap_o   = (int_i < INT_W'(GAP_MIN)) ? INT_W'(GAP_MIN) : int_i;
        half_m2 = half_o - DIV_W'(2);
        dly_ext = DIV_W'(dly_i);
        dly_o   = (dly_ext > half_m2) ? half_m2 : dly_ext;
    end
endmodule

// File: rtl/lsa_slot_decode.sv
// Classifies a slot number as dummy or real from the lead and real counts.
// Assumes slots are numbered from zero in readout order.
module lsa_slot_decode #(
    parameter int SLOT_W = 8,
    parameter int N_LEAD = 2,
    parameter int N_REAL = 128
) (
    input  logic [SLOT_W-1:0] idx_i,
    output logic              real_o
);
    // Real slots sit between the leading and trailing dummies.
    always_comb begin
        real_o = (idx_i >= SLOT_W'(N_LEAD)) && (idx_i < SLOT_W'(N_LEAD + N_REAL));
    end
endmodule

// File: rtl/lsa_sequencer.sv
// Readout sequencer for a linear photodiode array. It produces the start
// pulse and sensor clock, a per-slot sample strobe with slot tagging, and an
// enforced integration gap between frames.
// Assumes a single system clock. Settings are sampled when a frame begins.
module lsa_sequencer #(
    parameter longint unsigned SYS_HZ = 64'd100_000_000,
    parameter int DIV_W  = 16,
    parameter int INT_W  = 24,
    parameter int DLY_W  = 8,
    parameter int N_LEAD = 2,
    parameter int N_REAL = 128,
    parameter int N_TRAIL = 2,
    parameter int SLOT_W = $clog2(N_LEAD + N_REAL + N_TRAIL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [DLY_W-1:0]  dly_i,
    output logic              sens_si_o,
    output logic              sens_clk_o,
    output logic              pix_valid_o,
    output logic              pix_real_o,
    output logic [SLOT_W-1:0] pix_idx_o,
    output logic              frame_done_o,
    output logic              busy_o
);
    import lsa_pkg::*;

    localparam int N_SLOTS  = N_LEAD + N_REAL + N_TRAIL;
    localparam int HALF_MIN = int'(min_half(SYS_HZ));
    localparam int GAP_MIN  = int'(min_gap(SYS_HZ));
    localparam int CNT_W    = (INT_W > DIV_W) ? INT_W : DIV_W;

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot;
    logic              hi_ph;
    logic              pend;
    logic [DIV_W-1:0]  half_q, dly_q, half_c, dly_c;
    logic [INT_W-1:0]  gap_q, gap_c;
    logic [CNT_W-1:0]  half_m1, gap_m1, dly_cmp;

    lsa_param_clamp #(
        .DIV_W(DIV_W), .INT_W(INT_W), .DLY_W(DLY_W),
        .HALF_MIN(HALF_MIN), .GAP_MIN(GAP_MIN)
    ) u_clamp (
        .div_i(div_i), .int_i(int_i), .dly_i(dly_i),
        .half_o(half_c), .gap_o(gap_c), .dly_o(dly_c)
    );

    lsa_slot_decode #(
        .SLOT_W(SLOT_W), .N_LEAD(N_LEAD), .N_REAL(N_REAL)
    ) u_decode (
        .idx_i(pix_idx_o), .real_o(pix_real_o)
    );

    // Terminal counts for the phase timer, taken from the latched settings.
    always_comb begin
        half_m1 = CNT_W'(half_q) - CNT_W'(1);
        gap_m1  = CNT_W'(gap_q) - CNT_W'(1);
        dly_cmp = CNT_W'(dly_q);
        busy_o  = (state != ST_IDLE);
    end

    // Frame sequencing: start pulse, sensor clock phases, strobes and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            slot         <= '0;
            hi_ph        <= 1'b0;
            pend         <= 1'b0;
            half_q       <= DIV_W'(HALF_MIN);
            gap_q        <= INT_W'(GAP_MIN);
            dly_q        <= '0;
            sens_si_o    <= 1'b0;
            sens_clk_o   <= 1'b0;
            pix_valid_o  <= 1'b0;
            pix_idx_o    <= '0;
            frame_done_o <= 1'b0;
        end else begin
            pix_valid_o  <= 1'b0;
            frame_done_o <= 1'b0;
            if (start_i && state != ST_IDLE) pend <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start_i || pend || cont_i) begin
                        state     <= ST_SETUP;
                        sens_si_o <= 1'b1;
                        cnt       <= '0;
                        half_q    <= half_c;
                        gap_q     <= gap_c;
                        dly_q     <= dly_c;
                        pend      <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (cnt == half_m1) begin
                        state      <= ST_RUN;
                        sens_clk_o <= 1'b1;
                        hi_ph      <= 1'b1;
                        slot       <= '0;
                        cnt        <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    if (hi_ph) begin
                        if (cnt == half_m1) begin
                            sens_clk_o <= 1'b0;
                            sens_si_o  <= 1'b0;
                            hi_ph      <= 1'b0;
                            cnt        <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end else begin
                        if (cnt == dly_cmp) begin
                            pix_valid_o <= 1'b1;
                            pix_idx_o   <= slot;
                        end
                        if (cnt == half_m1) begin
                            cnt <= '0;
                            if (slot == SLOT_W'(N_SLOTS - 1)) begin
                                state        <= ST_GAP;
                                frame_done_o <= 1'b1;
                            end else begin
                                slot       <= slot + SLOT_W'(1);
                                sens_clk_o <= 1'b1;
                                hi_ph      <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt == gap_m1) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsa_sequencer_chk.sv
// Port-level protocol checks for lsa_sequencer, attached through bind.
// Assumes the default slot count of 132.
module lsa_sequencer_chk #(
    parameter int SLOT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sens_si_o,
    input logic              sens_clk_o,
    input logic              pix_valid_o,
    input logic [SLOT_W-1:0] pix_idx_o,
    input logic              frame_done_o,
    input logic              busy_o
);
    // R2
    si_one_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sens_clk_o) |-> !sens_si_o);

    // R5
    strobe_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> (!sens_clk_o && busy_o));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> (pix_idx_o < SLOT_W'(132)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (busy_o && !sens_clk_o && !sens_si_o));

    // R8
    si_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_si_o) |-> $rose(busy_o));
endmodule

bind lsa_sequencer lsa_sequencer_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sens_si_o(sens_si_o), .sens_clk_o(sens_clk_o),
    .pix_valid_o(pix_valid_o), .pix_idx_o(pix_idx_o),
    .frame_done_o(frame_done_o), .busy_o(busy_o)
);

// File: tb/sim_lsa_sequencer.sv
// Self-checking bench: directed clamp and request corner cases plus
// randomized settings in continuous mode, checked by a port monitor.
module sim_lsa_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [15:0] div_i = '0;
    logic [23:0] int_i = '0;
    logic [7:0]  dly_i = '0;
    logic        sens_si_o, sens_clk_o, pix_valid_o, pix_real_o;
    logic [7:0]  pix_idx_o;
    logic        frame_done_o, busy_o;

    int n_chk = 0;
    int n_err = 0;

    lsa_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .div_i(div_i), .int_i(int_i), .dly_i(dly_i),
        .sens_si_o(sens_si_o), .sens_clk_o(sens_clk_o),
        .pix_valid_o(pix_valid_o), .pix_real_o(pix_real_o),
        .pix_idx_o(pix_idx_o), .frame_done_o(frame_done_o), .busy_o(busy_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected values from the requirements (100 MHz system clock).
    function automatic int exp_half(input int d);
        return (d < 50) ? 50 : d;
    endfunction
    function automatic int exp_gap(input int g);
        return (g < 1000) ? 1000 : g;
    endfunction
    function automatic int exp_dly(input int d, input int h);
        return (d > h - 2) ? h - 2 : d;
    endfunction

    // Monitor state
    longint cyc = 0;
    int nxt_h = 50, nxt_i = 1000, nxt_d = 0;
    int cur_h = 50, cur_i = 1000, cur_d = 0;
    bit b2b = 1'b0;
    bit p_si = 1'b0, p_clk = 1'b0, p_done = 1'b0, in_frame = 1'b0;
    longint t_si = 0, t_edge = 0, t_fall = 0, t_done = 0;
    int rises = 0, falls = 0, strobes = 0, reals = 0;
    int ord_err = 0, wid_err = 0, dly_err = 0;
    int frames_started = 0, frames_done = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (sens_si_o && !p_si) begin
                // R8 gap after the previous frame, using that frame's latched gap
                if (frames_done > 0) begin
                    if (b2b) check((cyc - t_done) == cur_i + 1, "R8 exact gap", cyc - t_done, cur_i + 1);
                    else     check((cyc - t_done) >= cur_i + 1, "R8 minimum gap", cyc - t_done, cur_i + 1);
                end
                cur_h = nxt_h; cur_i = nxt_i; cur_d = nxt_d;
                t_si = cyc; in_frame = 1'b1; frames_started++;
                rises = 0; falls = 0; strobes = 0; reals = 0;
                ord_err = 0; wid_err = 0; dly_err = 0;
            end
            if (sens_clk_o && !p_clk) begin
                rises++;
                if (rises == 1) begin
                    check((cyc - t_si) == cur_h, "R2 R4 setup", cyc - t_si, cur_h);
                    check(sens_si_o, "R2 si held at capture", sens_si_o, 1);
                end else if ((cyc - t_edge) != cur_h) wid_err++;
                t_edge = cyc;
            end
            if (!sens_clk_o && p_clk) begin
                falls++;
                if ((cyc - t_edge) != cur_h) wid_err++;
                if (falls == 1) check(!sens_si_o, "R2 si low at first fall", sens_si_o, 0);
                t_edge = cyc; t_fall = cyc;
            end
            if (pix_valid_o) begin
                if ((cyc - t_fall) != cur_d + 1) dly_err++;
                if (int'(pix_idx_o) != strobes) ord_err++;
                if (pix_real_o != (pix_idx_o >= 2 && pix_idx_o <= 129)) ord_err++;
                if (!in_frame) ord_err++;
                if (pix_real_o) reals++;
                strobes++;
            end
            if (frame_done_o && p_done) check(1'b0, "R7 done width", 2, 1);
            if (frame_done_o && !p_done) begin
                check((cyc - t_fall) == cur_h, "R7 done timing", cyc - t_fall, cur_h);
                check(busy_o, "R7 busy through gap", busy_o, 1);
                check(rises == 132, "R3 pulse count", rises, 132);
                check(wid_err == 0, "R3 R4 phase widths", wid_err, 0);
                check(strobes == 132, "R5 strobe count", strobes, 132);
                check(dly_err == 0, "R5 strobe delay", dly_err, 0);
                check(reals == 128, "R6 real count", reals, 128);
                check(ord_err == 0, "R6 slot order and tags", ord_err, 0);
                in_frame = 1'b0; t_done = cyc; frames_done++;
            end
            if (pix_valid_o && !in_frame) check(1'b0, "R5 strobe outside frame", 1, 0);
        end
        p_si = sens_si_o; p_clk = sens_clk_o; p_done = frame_done_o;
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!sens_si_o && !sens_clk_o && !pix_valid_o && !frame_done_o && !busy_o,
              "R1 outputs during reset", {sens_si_o, sens_clk_o, pix_valid_o, frame_done_o, busy_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!sens_si_o && !busy_o, "R1 idle after reset", {sens_si_o, busy_o}, 0);

        // Frame A: every setting below its floor, delay too long (R4 R5 R8)
        div_i = 16'd10; int_i = 24'd5; dly_i = 8'd200;
        nxt_h = exp_half(10); nxt_i = exp_gap(5); nxt_d = exp_dly(200, nxt_h);
        b2b = 1'b0;
        pulse_start();
        repeat (600) @(negedge clk);
        // Frame B: settings change and a request arrives mid-frame (R9)
        div_i = 16'd51; int_i = 24'd1200; dly_i = 8'd0;
        nxt_h = exp_half(51); nxt_i = exp_gap(1200); nxt_d = exp_dly(0, 51);
        b2b = 1'b1;
        pulse_start();
        while (frames_done < 2) @(negedge clk);
        wait_idle();
        repeat (200) @(negedge clk);
        check(frames_started == 2, "R9 one held frame", frames_started, 2);
        check(!sens_si_o && !busy_o, "R9 idle after held frame", {sens_si_o, busy_o}, 0);

        // Frames C and D: random settings, continuous mode (R10)
        begin
            int d = 50 + int'($urandom % 7);
            int g = 1000 + int'($urandom % 400);
            int s = int'($urandom % 70);
            div_i = 16'(d); int_i = 24'(g); dly_i = 8'(s);
            nxt_h = exp_half(d); nxt_i = exp_gap(g); nxt_d = exp_dly(s, nxt_h);
        end
        b2b = 1'b0;
        @(negedge clk); cont_i = 1'b1;
        while (!sens_si_o) @(negedge clk);
        @(negedge clk); b2b = 1'b1;
        while (frames_done < 4) @(negedge clk);
        cont_i = 1'b0;
        wait_idle();
        repeat (3000) @(negedge clk);
        check(frames_started == 4, "R10 stop after drop", frames_started, 4);
        check(!sens_si_o && !sens_clk_o && !busy_o, "R10 lines quiet", {sens_si_o, sens_clk_o, busy_o}, 0);
        finish_run();
    end
endmodule